// File: doc/BRIEF.md
# Video Scaler Kernel Control Register Block

This block is the memory-mapped slave that software uses to configure and launch a streaming horizontal video scaling kernel. It holds a control word with the kernel launch handshake (launch request, sticky completion flag, idle and ready views, and an automatic relaunch option), a master interrupt gate, per-channel interrupt enables and interrupt status, and six frame parameter fields. It also holds two packed lookup tables for the kernel: one for filter coefficients and one for phase values. The kernel reads these through index ports.

Software reaches the block through a simple word-oriented register port. An address comes with either a write strobe and write data, or a read strobe. Read data is registered and appears one cycle after the read strobe. The kernel side consists of the launch output, three status inputs (completion pulse, idle level and ready pulse), the frame parameters as outputs, and the two table index and value pairs. A single level-sensitive interrupt output is derived from the status bits.

Top module: `hscale_csr`

## Requirements
- R1: After reset the launch, completion, auto-relaunch, interrupt gate, enables and status are all 0, every frame parameter is 0, `irq` is low and a control-word read returns only the idle view.
- R2: Writing a 1 to control bit 0 (byte offset 0x000) raises `krn_start`. Writing a 0 there does not lower it. When `krn_ready` is sampled high while auto-relaunch is off, `krn_start` falls in the next cycle.
- R3: Control bit 7 is a read/write auto-relaunch flag. While it is set, a `krn_ready` pulse during a launch leaves `krn_start` high for the next run. Once the flag is cleared, the next `krn_ready` ends the launch.
- R4: Control bit 1 is read-only. It is set by a `krn_done` pulse and cleared by a read of the control word. If a pulse and a clearing read fall in the same cycle, the bit ends up set.
- R5: Control bit 2 shows `krn_idle` and control bit 3 shows `krn_ready`, as sampled in the cycle of the read strobe.
- R6: Interrupt status (0x00C) bit 0 is set by `krn_done` when enable bit 0 at 0x008 is 1. Status bit 1 is set by `krn_ready` when enable bit 1 is 1. With an enable at 0, the matching event leaves its status bit unchanged.
- R7: Writing 0x00C inverts each status bit whose write-data bit is 1. An enabled event in the same cycle leaves its status bit at 1.
- R8: `irq` is high exactly when bit 0 at 0x004 is 1 and at least one status bit is 1.
- R9: Frame parameters occupy the low bits of their words: 16-bit height (0x010), input width (0x018) and output width (0x020), and 8-bit input colour mode (0x028), pixel rate (0x030) and output colour mode (0x038). Wider write data is truncated, upper bits read 0, and each value appears on its `cfg_*` output.
- R10: The coefficient window starts at 0x400. Word n holds 16-bit entry 2n in bits 15:0 and entry 2n+1 in bits 31:16, across 384 entries (192 words). `coef_val` returns the entry selected by `coef_idx`.
- R11: The phase window starts at 0x4000. Word n holds 9-bit entry 2n in bits 8:0 and entry 2n+1 in bits 24:16, across 8192 entries. All other bits read 0, and `phase_val` returns the entry selected by `phase_idx`.
- R12: Unassigned offsets, including unused words inside the coefficient window, read 0, and writes to them change nothing.
- R13: `bus_rdata` updates on the clock edge that samples `bus_re` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 15 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| krn_start | output | 1 | Launch request to the kernel |
| krn_done | input | 1 | Kernel completion pulse |
| krn_idle | input | 1 | Kernel idle level |
| krn_ready | input | 1 | Kernel accepts launch pulse |
| irq | output | 1 | Interrupt request |
| cfg_height | output | 16 | Frame height |
| cfg_width_in | output | 16 | Input line width |
| cfg_width_out | output | 16 | Output line width |
| cfg_color_in | output | 8 | Input colour mode |
| cfg_pix_rate | output | 8 | Pixel rate |
| cfg_color_out | output | 8 | Output colour mode |
| coef_idx | input | 9 | Coefficient entry index from the kernel |
| coef_val | output | 16 | Selected coefficient |
| phase_idx | input | 13 | Phase entry index from the kernel |
| phase_val | output | 9 | Selected phase value |

## Verification
The cases that are hard to reach from the ports are the collisions: a completion pulse arriving in the very cycle that software reads the control word, and an enabled event arriving in the very cycle that software toggles its status bit. Software is slow and the kernel is asynchronous to it, so these coincidences almost never occur naturally. The bench creates them on purpose by driving the kernel pulse and the bus strobe on the same falling edge. It then reads back to confirm that the event was not lost.

// File: rtl/hscale_csr_pkg.sv
`timescale 1ns/1ps
package hscale_csr_pkg;

  // handshake / interrupt word offsets (byte addresses)
  localparam int unsigned OFF_CTRL = 'h000;
  localparam int unsigned OFF_GIE  = 'h004;
  localparam int unsigned OFF_IER  = 'h008;
  localparam int unsigned OFF_ISR  = 'h00C;

  // control word bit positions
  localparam int unsigned CTRL_START = 0;
  localparam int unsigned CTRL_DONE  = 1;
  localparam int unsigned CTRL_IDLE  = 2;
  localparam int unsigned CTRL_READY = 3;
  localparam int unsigned CTRL_AUTO  = 7;

  // interrupt channels
  localparam int unsigned CH_DONE  = 0;
  localparam int unsigned CH_READY = 1;
  localparam int unsigned NUM_CH   = 2;

  // frame parameter bank
  localparam int unsigned CFG_N = 6;
  typedef enum logic [2:0] {
    CFG_HEIGHT, CFG_WIDTH_IN, CFG_WIDTH_OUT, CFG_COLOR_IN, CFG_RATE, CFG_COLOR_OUT
  } cfg_field_e;

  localparam int unsigned CFG_OFF [CFG_N] = '{'h010, 'h018, 'h020, 'h028, 'h030, 'h038};
  localparam int unsigned CFG_WID [CFG_N] = '{16, 16, 16, 8, 8, 8};

  function automatic logic [15:0] cfg_mask(input int unsigned w);
    return 16'((32'd1 << w) - 32'd1);
  endfunction

endpackage

// File: rtl/hscale_csr_ctrl.sv
`timescale 1ns/1ps
module hscale_csr_ctrl
  import hscale_csr_pkg::*;
#(
  parameter int unsigned WIDX_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [WIDX_W-1:0] idx,
  input  logic [7:0]        wdata,
  input  logic              krn_done,
  input  logic              krn_idle,
  input  logic              krn_ready,
  output logic              krn_start,
  output logic              irq,
  output logic [31:0]       rd_val
);

  localparam logic [WIDX_W-1:0] I_CTRL = WIDX_W'(OFF_CTRL >> 2);
  localparam logic [WIDX_W-1:0] I_GIE  = WIDX_W'(OFF_GIE  >> 2);
  localparam logic [WIDX_W-1:0] I_IER  = WIDX_W'(OFF_IER  >> 2);
  localparam logic [WIDX_W-1:0] I_ISR  = WIDX_W'(OFF_ISR  >> 2);

  logic              start_q, start_d;
  logic              auto_q, auto_d;
  logic              done_q, done_d;
  logic              gie_q, gie_d;
  logic [NUM_CH-1:0] ier_q, ier_d;
  logic [NUM_CH-1:0] isr_q, isr_d;
  logic [NUM_CH-1:0] ev, tog;
  logic              wr_ctrl, rd_ctrl;
  logic              unused_wd;

  assign unused_wd = ^wdata[6:2];

  // next-state
  always_comb begin
    wr_ctrl = wr_en && (idx == I_CTRL);
    rd_ctrl = rd_en && (idx == I_CTRL);

    ev           = '0;
    ev[CH_DONE]  = krn_done  & ier_q[CH_DONE];
    ev[CH_READY] = krn_ready & ier_q[CH_READY];
    tog          = (wr_en && (idx == I_ISR)) ? wdata[NUM_CH-1:0] : '0;

    // launch persists until accepted; auto-relaunch keeps it up across acceptance
    start_d = (wr_ctrl & wdata[CTRL_START]) | (start_q & (~krn_ready | auto_q));
    auto_d  = wr_ctrl ? wdata[CTRL_AUTO] : auto_q;
    // completion event takes priority over the clearing read
    done_d  = krn_done | (done_q & ~rd_ctrl);
    gie_d   = (wr_en && (idx == I_GIE)) ? wdata[0] : gie_q;
    ier_d   = (wr_en && (idx == I_IER)) ? wdata[NUM_CH-1:0] : ier_q;
    // events take priority over the toggle
    isr_d   = (isr_q ^ tog) | ev;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      auto_q  <= 1'b0;
      done_q  <= 1'b0;
      gie_q   <= 1'b0;
      ier_q   <= '0;
      isr_q   <= '0;
    end else begin
      start_q <= start_d;
      auto_q  <= auto_d;
      done_q  <= done_d;
      gie_q   <= gie_d;
      ier_q   <= ier_d;
      isr_q   <= isr_d;
    end
  end

  assign krn_start = start_q;
  assign irq       = gie_q & (|isr_q);

  // read view
  always_comb begin
    rd_val = '0;
    unique case (idx)
      I_CTRL: begin
        rd_val[CTRL_START] = start_q;
        rd_val[CTRL_DONE]  = done_q;
        rd_val[CTRL_IDLE]  = krn_idle;
        rd_val[CTRL_READY] = krn_ready;
        rd_val[CTRL_AUTO]  = auto_q;
      end
      I_GIE:   rd_val[0]            = gie_q;
      I_IER:   rd_val[NUM_CH-1:0]   = ier_q;
      I_ISR:   rd_val[NUM_CH-1:0]   = isr_q;
      default: rd_val               = '0;
    endcase
  end

endmodule

// File: rtl/hscale_csr_cfg.sv
`timescale 1ns/1ps
module hscale_csr_cfg
  import hscale_csr_pkg::*;
#(
  parameter int unsigned WIDX_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] idx,
  input  logic [31:0]       wdata,
  output logic [15:0]       fld [CFG_N],
  output logic [31:0]       rd_val
);

  logic unused_wd;
  assign unused_wd = ^wdata[31:16];

  for (genvar g = 0; g < CFG_N; g++) begin : g_fld
    localparam logic [WIDX_W-1:0] MY_IDX = WIDX_W'(CFG_OFF[g] >> 2);
    localparam logic [15:0]       MASK   = cfg_mask(CFG_WID[g]);

    logic        hit;
    logic [15:0] q;

    assign hit = wr_en && (idx == MY_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (hit) begin
        q <= wdata[15:0] & MASK;
      end
    end

    assign fld[g] = q;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < CFG_N; i++) begin
      if (idx == WIDX_W'(CFG_OFF[i] >> 2)) rd_val[15:0] = fld[i];
    end
  end

endmodule

// File: rtl/hscale_csr_table.sv
`timescale 1ns/1ps
module hscale_csr_table #(
  parameter int unsigned ENTRY_W = 16,
  parameter int unsigned ENTRIES = 384,
  parameter int unsigned IDX_W   = 8,
  localparam int unsigned WORDS   = ENTRIES / 2,
  localparam int unsigned WORD_AW = $clog2(WORDS),
  localparam int unsigned ENT_AW  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   idx,
  input  logic [31:0]        wdata,
  output logic [31:0]        rd_word,
  input  logic [ENT_AW-1:0]  ent_idx,
  output logic [ENTRY_W-1:0] ent_val
);

  logic [2*ENTRY_W-1:0] mem [WORDS];
  logic                 in_rng;
  logic                 ent_ok;
  logic [WORD_AW-1:0]   ent_word;
  logic [2*ENTRY_W-1:0] sel_word;
  logic                 unused_wd;

  assign unused_wd = ^wdata;
  assign in_rng    = {1'b0, idx} < (IDX_W+1)'(WORDS);

  // storage: two entries per bus word, clock enable on write
  always_ff @(posedge clk) begin
    if (wr_en && in_rng) begin
      mem[idx[WORD_AW-1:0]] <= {wdata[16 +: ENTRY_W], wdata[0 +: ENTRY_W]};
    end
  end

  // bus view: entry 2n in the low half, entry 2n+1 in the high half
  always_comb begin
    rd_word = '0;
    if (in_rng) begin
      rd_word[0  +: ENTRY_W] = mem[idx[WORD_AW-1:0]][ENTRY_W-1:0];
      rd_word[16 +: ENTRY_W] = mem[idx[WORD_AW-1:0]][2*ENTRY_W-1:ENTRY_W];
    end
  end

  // kernel view
  assign ent_ok   = {1'b0, ent_idx} < (ENT_AW+1)'(ENTRIES);
  assign ent_word = WORD_AW'(ent_idx >> 1);
  assign sel_word = mem[ent_word];

  always_comb begin
    if (!ent_ok)        ent_val = '0;
    else if (ent_idx[0]) ent_val = sel_word[2*ENTRY_W-1:ENTRY_W];
    else                ent_val = sel_word[ENTRY_W-1:0];
  end

endmodule

// File: rtl/hscale_csr.sv
`timescale 1ns/1ps
module hscale_csr
  import hscale_csr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned COEF_W     = 16,
  parameter int unsigned COEF_N     = 384,
  parameter int unsigned PHASE_W    = 9,
  parameter int unsigned PHASE_N    = 8192,
  parameter int unsigned COEF_BASE  = 'h400,
  parameter int unsigned COEF_SPAN  = 'h400,
  parameter int unsigned PHASE_BASE = 'h4000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  input  logic                       bus_we,
  input  logic                       bus_re,
  output logic [31:0]                bus_rdata,
  output logic                       krn_start,
  input  logic                       krn_done,
  input  logic                       krn_idle,
  input  logic                       krn_ready,
  output logic                       irq,
  output logic [15:0]                cfg_height,
  output logic [15:0]                cfg_width_in,
  output logic [15:0]                cfg_width_out,
  output logic [7:0]                 cfg_color_in,
  output logic [7:0]                 cfg_pix_rate,
  output logic [7:0]                 cfg_color_out,
  input  logic [$clog2(COEF_N)-1:0]  coef_idx,
  output logic [COEF_W-1:0]          coef_val,
  input  logic [$clog2(PHASE_N)-1:0] phase_idx,
  output logic [PHASE_W-1:0]         phase_val
);

  localparam int unsigned WIDX_W     = ADDR_W - 2;
  localparam int unsigned COEF_IW    = $clog2(COEF_SPAN / 4);
  localparam int unsigned PHASE_SPAN = (1 << ADDR_W) - PHASE_BASE;
  localparam int unsigned PHASE_IW   = $clog2(PHASE_SPAN / 4);
  localparam logic [ADDR_W:0] COEF_LO  = (ADDR_W+1)'(COEF_BASE);
  localparam logic [ADDR_W:0] COEF_HI  = (ADDR_W+1)'(COEF_BASE + COEF_SPAN);
  localparam logic [ADDR_W:0] PHASE_LO = (ADDR_W+1)'(PHASE_BASE);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // address decode
  logic [ADDR_W:0]   addr_x;
  logic [WIDX_W-1:0] widx;
  logic              coef_hit, phase_hit;
  logic [COEF_IW-1:0]  coef_widx;
  logic [PHASE_IW-1:0] phase_widx;

  assign addr_x     = {1'b0, bus_addr};
  assign widx       = bus_addr[ADDR_W-1:2];
  assign coef_hit   = (addr_x >= COEF_LO) && (addr_x < COEF_HI);
  assign phase_hit  = (addr_x >= PHASE_LO);
  assign coef_widx  = COEF_IW'((addr_x - COEF_LO) >> 2);
  assign phase_widx = PHASE_IW'((addr_x - PHASE_LO) >> 2);

  // handshake and interrupt logic
  logic [31:0] ctrl_rd;

  hscale_csr_ctrl #(.WIDX_W(WIDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (bus_we),
    .rd_en     (bus_re),
    .idx       (widx),
    .wdata     (bus_wdata[7:0]),
    .krn_done  (krn_done),
    .krn_idle  (krn_idle),
    .krn_ready (krn_ready),
    .krn_start (krn_start),
    .irq       (irq),
    .rd_val    (ctrl_rd)
  );

  // frame parameters
  logic [15:0] fld [CFG_N];
  logic [31:0] cfg_rd;
  logic        unused_hi;

  hscale_csr_cfg #(.WIDX_W(WIDX_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (bus_we),
    .idx    (widx),
    .wdata  (bus_wdata),
    .fld    (fld),
    .rd_val (cfg_rd)
  );

  assign cfg_height    = fld[CFG_HEIGHT];
  assign cfg_width_in  = fld[CFG_WIDTH_IN];
  assign cfg_width_out = fld[CFG_WIDTH_OUT];
  assign cfg_color_in  = fld[CFG_COLOR_IN][7:0];
  assign cfg_pix_rate  = fld[CFG_RATE][7:0];
  assign cfg_color_out = fld[CFG_COLOR_OUT][7:0];
  assign unused_hi     = ^{fld[CFG_COLOR_IN][15:8], fld[CFG_RATE][15:8], fld[CFG_COLOR_OUT][15:8]};

  // lookup tables
  logic [31:0] coef_word, phase_word;

  hscale_csr_table #(.ENTRY_W(COEF_W), .ENTRIES(COEF_N), .IDX_W(COEF_IW)) u_coef (
    .clk     (clk),
    .wr_en   (bus_we & coef_hit),
    .idx     (coef_widx),
    .wdata   (bus_wdata),
    .rd_word (coef_word),
    .ent_idx (coef_idx),
    .ent_val (coef_val)
  );

  hscale_csr_table #(.ENTRY_W(PHASE_W), .ENTRIES(PHASE_N), .IDX_W(PHASE_IW)) u_phase (
    .clk     (clk),
    .wr_en   (bus_we & phase_hit),
    .idx     (phase_widx),
    .wdata   (bus_wdata),
    .rd_word (phase_word),
    .ent_idx (phase_idx),
    .ent_val (phase_val)
  );

  // read return, captured on the read strobe
  logic [31:0] rd_mux, rdata_q;

  always_comb begin
    rd_mux = ctrl_rd | cfg_rd;
    if (coef_hit)  rd_mux = rd_mux | coef_word;
    if (phase_hit) rd_mux = rd_mux | phase_word;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (bus_re)  rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/hscale_csr_chk.sv
`timescale 1ns/1ps
module hscale_csr_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [31:0]       bus_rdata,
  input logic              krn_start,
  input logic              krn_done,
  input logic              krn_idle,
  input logic              krn_ready,
  input logic              irq,
  input logic              auto_q,
  input logic              done_q,
  input logic              gie_q,
  input logic [1:0]        ier_q,
  input logic [1:0]        isr_q
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] A_GIE  = ADDR_W'('h004);
  localparam logic [ADDR_W-1:0] A_ISR  = ADDR_W'('h00C);
  localparam logic [ADDR_W-1:0] A_RSVD = ADDR_W'('h014);

  assert_start_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (krn_start && krn_ready && !auto_q && !(bus_we && bus_addr == A_CTRL && bus_wdata[0]))
    |=> !krn_start);

  assert_relaunch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (krn_start && krn_ready && auto_q) |=> krn_start);

  assert_done_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    krn_done |=> done_q);

  assert_done_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && bus_re && bus_addr == A_CTRL && !krn_done) |=> !done_q);

  assert_idle_view_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == A_CTRL) |=> (bus_rdata[2] == $past(krn_idle)));

  assert_isr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (krn_done && ier_q[0]) |=> isr_q[0]);

  assert_isr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!krn_done && !(bus_we && bus_addr == A_ISR)) |=> $stable(isr_q[0]));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_GIE && !bus_wdata[0]) |=> !irq);

  assert_rsvd_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == A_RSVD) |=> (bus_rdata == 32'h0));

endmodule

bind hscale_csr hscale_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .krn_start (krn_start),
  .krn_done  (krn_done),
  .krn_idle  (krn_idle),
  .krn_ready (krn_ready),
  .irq       (irq),
  .auto_q    (u_ctrl.auto_q),
  .done_q    (u_ctrl.done_q),
  .gie_q     (u_ctrl.gie_q),
  .ier_q     (u_ctrl.ier_q),
  .isr_q     (u_ctrl.isr_q)
);

// File: tb/sim_hscale_csr.sv
`timescale 1ns/1ps
module sim_hscale_csr;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        krn_start, krn_done = 1'b0, krn_idle = 1'b1, krn_ready = 1'b0, irq;
  logic [15:0] cfg_height, cfg_width_in, cfg_width_out;
  logic [7:0]  cfg_color_in, cfg_pix_rate, cfg_color_out;
  logic [8:0]  coef_idx = '0;
  logic [15:0] coef_val;
  logic [12:0] phase_idx = '0;
  logic [8:0]  phase_val;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  hscale_csr u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .krn_start(krn_start), .krn_done(krn_done), .krn_idle(krn_idle),
    .krn_ready(krn_ready), .irq(irq),
    .cfg_height(cfg_height), .cfg_width_in(cfg_width_in), .cfg_width_out(cfg_width_out),
    .cfg_color_in(cfg_color_in), .cfg_pix_rate(cfg_pix_rate), .cfg_color_out(cfg_color_out),
    .coef_idx(coef_idx), .coef_val(coef_val), .phase_idx(phase_idx), .phase_val(phase_val)
  );

  // {requirement number, address, write data, expected readback}
  // R9 parameter fields, R12 reserved words, R10 coefficient window, R11 phase window
  localparam int NV = 13;
  localparam logic [87:0] VEC [NV] = '{
    {8'd9,  16'h0010, 32'hABCD_1234, 32'h0000_1234},
    {8'd9,  16'h0018, 32'hFFFF_8001, 32'h0000_8001},
    {8'd9,  16'h0020, 32'h0000_0280, 32'h0000_0280},
    {8'd9,  16'h0028, 32'h0000_0123, 32'h0000_0023},
    {8'd9,  16'h0030, 32'hDEAD_BEEF, 32'h0000_00EF},
    {8'd9,  16'h0038, 32'h5A5A_5AA5, 32'h0000_00A5},
    {8'd12, 16'h0014, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'd12, 16'h0040, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'd10, 16'h0400, 32'h1234_5678, 32'h1234_5678},
    {8'd10, 16'h06FC, 32'hCAFE_BABE, 32'hCAFE_BABE},
    {8'd12, 16'h0700, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'd11, 16'h4000, 32'hFFFF_FFFF, 32'h01FF_01FF},
    {8'd11, 16'h7FFC, 32'h0155_0AAA, 32'h0155_00AA}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [14:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // R13: data is valid at the falling edge after the sampling edge
  task automatic bus_read(input logic [14:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); krn_done = 1'b1;
    @(negedge clk); krn_done = 1'b0;
  endtask

  task automatic pulse_ready();
    @(negedge clk); krn_ready = 1'b1;
    @(negedge clk); krn_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 start", {31'b0, krn_start}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 height", {16'b0, cfg_height}, 32'h0);
    bus_read(15'h000, rd); chk("R1 ctrl", rd, 32'h0000_0004);
    bus_read(15'h00C, rd); chk("R1 isr", rd, 32'h0);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i][79:64], VEC[i][63:32]);
      bus_read(VEC[i][79:64], rd);
      chk($sformatf("R%0d vec%0d", VEC[i][87:80], i), rd, VEC[i][31:0]);
    end

    // R9 outputs; R12 reserved write at 0x014 left height intact
    chk("R9 height", {16'b0, cfg_height}, 32'h1234);
    chk("R9 width_in", {16'b0, cfg_width_in}, 32'h8001);
    chk("R9 width_out", {16'b0, cfg_width_out}, 32'h0280);
    chk("R9 color_in", {24'b0, cfg_color_in}, 32'h23);
    chk("R9 rate", {24'b0, cfg_pix_rate}, 32'hEF);
    chk("R9 color_out", {24'b0, cfg_color_out}, 32'hA5);

    // R10 kernel coefficient view
    coef_idx = 9'd0;   #1 chk("R10 coef0", {16'b0, coef_val}, 32'h5678);
    coef_idx = 9'd1;   #1 chk("R10 coef1", {16'b0, coef_val}, 32'h1234);
    coef_idx = 9'd383; #1 chk("R10 coef383", {16'b0, coef_val}, 32'hCAFE);
    // R11 kernel phase view
    phase_idx = 13'd0;    #1 chk("R11 phase0", {23'b0, phase_val}, 32'h1FF);
    phase_idx = 13'd8190; #1 chk("R11 phase8190", {23'b0, phase_val}, 32'h0AA);
    phase_idx = 13'd8191; #1 chk("R11 phase8191", {23'b0, phase_val}, 32'h155);

    // R13 read latency
    bus_read(15'h014, rd);
    @(negedge clk); bus_addr = 15'h010; bus_re = 1'b1;
    #1 chk("R13 before edge", bus_rdata, 32'h0);
    @(negedge clk); bus_re = 1'b0;
    chk("R13 after edge", bus_rdata, 32'h1234);
    repeat (2) @(negedge clk);
    chk("R13 hold", bus_rdata, 32'h1234);

    // R2 launch handshake
    bus_write(15'h000, 32'h1);
    chk("R2 set", {31'b0, krn_start}, 32'h1);
    bus_write(15'h000, 32'h0);
    chk("R2 write0 keeps", {31'b0, krn_start}, 32'h1);
    pulse_ready();
    chk("R2 cleared by ready", {31'b0, krn_start}, 32'h0);

    // R5 idle and ready views
    krn_idle = 1'b0;
    bus_read(15'h000, rd); chk("R5 idle low", rd, 32'h0);
    @(negedge clk); krn_ready = 1'b1;
    bus_read(15'h000, rd); chk("R5 ready view", rd, 32'h8);
    krn_ready = 1'b0; krn_idle = 1'b1;
    bus_read(15'h000, rd); chk("R5 idle high", rd, 32'h4);

    // R4 sticky completion
    pulse_done();
    bus_read(15'h000, rd); chk("R4 done set", rd, 32'h6);
    bus_read(15'h000, rd); chk("R4 done cleared", rd, 32'h4);
    @(negedge clk); krn_done = 1'b1; bus_addr = 15'h000; bus_re = 1'b1;
    @(negedge clk); krn_done = 1'b0; bus_re = 1'b0;
    chk("R4 collide read", bus_rdata, 32'h4);
    bus_read(15'h000, rd); chk("R4 event wins", rd, 32'h6);
    bus_read(15'h000, rd); chk("R4 cleared after", rd, 32'h4);

    // R6 status capture
    bus_read(15'h00C, rd); chk("R6 disabled no set", rd, 32'h0);
    bus_write(15'h008, 32'h3);
    pulse_done();
    bus_read(15'h00C, rd); chk("R6 done ch", rd, 32'h1);
    chk("R8 gated off", {31'b0, irq}, 32'h0);
    pulse_ready();
    bus_read(15'h00C, rd); chk("R6 ready ch", rd, 32'h3);
    bus_write(15'h004, 32'h1);
    chk("R8 irq on", {31'b0, irq}, 32'h1);

    // R7 toggle on write
    bus_write(15'h00C, 32'h1);
    bus_read(15'h00C, rd); chk("R7 toggle bit0", rd, 32'h2);
    chk("R8 irq still", {31'b0, irq}, 32'h1);
    bus_write(15'h00C, 32'h2);
    bus_read(15'h00C, rd); chk("R7 toggle bit1", rd, 32'h0);
    chk("R8 irq off", {31'b0, irq}, 32'h0);
    bus_write(15'h00C, 32'h1);
    bus_read(15'h00C, rd); chk("R7 toggle sets", rd, 32'h1);
    @(negedge clk); krn_done = 1'b1; bus_addr = 15'h00C; bus_wdata = 32'h1; bus_we = 1'b1;
    @(negedge clk); krn_done = 1'b0; bus_we = 1'b0;
    bus_read(15'h00C, rd); chk("R7 event beats toggle", rd, 32'h1);
    bus_write(15'h004, 32'h0);
    chk("R8 gie off", {31'b0, irq}, 32'h0);
    bus_write(15'h00C, 32'h1);

    // R3 auto-relaunch
    bus_read(15'h000, rd);
    bus_write(15'h000, 32'h81);
    bus_read(15'h000, rd); chk("R3 ctrl view", rd, 32'h85);
    pulse_ready();
    chk("R3 relaunch 1", {31'b0, krn_start}, 32'h1);
    pulse_ready();
    chk("R3 relaunch 2", {31'b0, krn_start}, 32'h1);
    bus_write(15'h000, 32'h0);
    chk("R3 auto off keeps", {31'b0, krn_start}, 32'h1);
    pulse_ready();
    chk("R3 stops", {31'b0, krn_start}, 32'h0);
    pulse_ready();
    chk("R3 stays stopped", {31'b0, krn_start}, 32'h0);
    bus_read(15'h000, rd); chk("R3 ctrl final", rd, 32'h4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule